// File: doc/BRIEF.md
# SAD Block-Matching Minimum Search

This block scores a stream of 4x4 candidate pixel blocks against one stored 4x4 reference block. It reports the candidate with the smallest sum of absolute differences (SAD). The reference is captured once with a load strobe. A start pulse then opens a new search. After that, candidates arrive one per cycle, qualified by a valid flag, and each carries sixteen pixels and an index tag.

For every accepted candidate, sixteen absolute-difference units work in parallel. Their outputs are summed into one SAD, which is registered. In the next cycle the registered SAD is compared with the running minimum. Every magnitude decision, both per pixel and for the running minimum, uses one comparator form: the carry out of `B + ~A + 1`. When the candidate flagged as last has passed through both stages, the block raises a one-cycle done pulse. The best SAD and its index are shown at the same time.

Top module: `sad_min_search`

## Requirements
- R1: `ref_load` captures `ref_pix` on the clock edge. Pixel k sits in bits [8k+7:8k] of both `ref_pix` and `cand_pix`, and candidate pixel k is always paired with stored reference pixel k.
- R2: Each pixel term is |cand - ref| of two 8-bit unsigned values, selected by the carry of a two's-complement subtract. It is symmetric: a candidate 10 above the reference scores the same as one 10 below.
- R3: The SAD of a candidate is the sum of its 16 pixel terms, held in 12 bits without overflow. All-zero against all-255 gives 4080.
- R4: A `start` pulse makes `best_sad` read 4095 and `best_idx` read 0 in the next cycle. A candidate accepted in the cycle before `start` is discarded.
- R5: A candidate is accepted on every cycle in which `cand_valid` is high, with no backpressure. Pixels and index presented while `cand_valid` is low have no effect on the result.
- R6: After a candidate's SAD is compared, `best_sad`/`best_idx` hold the smallest SAD and its index among the candidates accepted since the last `start`.
- R7: When a new SAD equals the stored minimum, the stored index (the earlier candidate) is kept.
- R8: If the last-flagged candidate is presented with `cand_valid` in cycle c, `done` is high for exactly one cycle, in cycle c+2. The final `best_sad` and `best_idx` are shown in that same cycle.
- R9: After reset, `done` is 0, `best_sad` is 4095 and `best_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_load | input | 1 | Capture the reference block |
| ref_pix | input | 128 | Reference pixels, pixel k at [8k+7:8k] |
| start | input | 1 | Begin a new search |
| cand_valid | input | 1 | Candidate present this cycle |
| cand_last | input | 1 | Candidate is the final one of the search |
| cand_pix | input | 128 | Candidate pixels, pixel k at [8k+7:8k] |
| cand_idx | input | 8 | Candidate index tag |
| done | output | 1 | One-cycle pulse: search result ready |
| best_sad | output | 12 | Smallest SAD so far |
| best_idx | output | 8 | Index of the candidate with the smallest SAD |

## Verification
Some properties are checked by assertions on every cycle:
- a registered SAD never exceeds 4080;
- the minimum never rises between start pulses;
- `start` leaves 4095 in the minimum register;
- a tie or a larger SAD leaves the stored index untouched;
- a flagged last candidate in the pipeline always produces a done pulse.

The bench scenarios are needed for the rest. They show the pixel pairing by position, the symmetry of the difference, the 4080 extreme, that invalid cycles are ignored, and that a candidate already in flight is dropped by `start`. A behavioural model is compared with the outputs on every clock.

// File: rtl/sad_min_search.sv
module sad_min_search #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int IDX_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ref_load,
  input  logic [ROWS*COLS*PIX_W-1:0]  ref_pix,
  input  logic                        start,
  input  logic                        cand_valid,
  input  logic                        cand_last,
  input  logic [ROWS*COLS*PIX_W-1:0]  cand_pix,
  input  logic [IDX_W-1:0]            cand_idx,
  output logic                        done,
  output logic [PIX_W+$clog2(ROWS*COLS)-1:0] best_sad,
  output logic [IDX_W-1:0]            best_idx
);

  localparam int NPIX    = ROWS * COLS;
  localparam int SAD_W   = PIX_W + $clog2(NPIX);
  localparam int BUS_W   = NPIX * PIX_W;
  localparam int SAD_MAX = NPIX * ((1 << PIX_W) - 1);

  // Subtract-and-carry comparator: result[W] = 1 when a >= b, low bits = a - b.
  function automatic logic [PIX_W:0] sub_pix(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    return {1'b0, a} + {1'b0, ~b} + {{PIX_W{1'b0}}, 1'b1};
  endfunction

  function automatic logic ge_sad(input logic [SAD_W-1:0] a, input logic [SAD_W-1:0] b);
    logic [SAD_W:0] s;
    s = {1'b0, a} + {1'b0, ~b} + {{SAD_W{1'b0}}, 1'b1};
    return s[SAD_W];
  endfunction

  logic [BUS_W-1:0] ref_q;
  logic [PIX_W-1:0] ad [NPIX];
  logic [SAD_W-1:0] sad_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ref_q <= '0;
    else if (ref_load) ref_q <= ref_pix;

  for (genvar g = 0; g < NPIX; g++) begin : g_absdiff
    logic [PIX_W:0] c_minus_r, r_minus_c;
    assign c_minus_r = sub_pix(cand_pix[g*PIX_W +: PIX_W], ref_q[g*PIX_W +: PIX_W]);
    assign r_minus_c = sub_pix(ref_q[g*PIX_W +: PIX_W], cand_pix[g*PIX_W +: PIX_W]);
    assign ad[g] = c_minus_r[PIX_W] ? c_minus_r[PIX_W-1:0] : r_minus_c[PIX_W-1:0];
  end

  always_comb begin
    sad_c = '0;
    for (int i = 0; i < NPIX; i++) sad_c = sad_c + SAD_W'(ad[i]);
  end

  // Stage 1: registered SAD
  logic [SAD_W-1:0] sad_q;
  logic [IDX_W-1:0] idx_q;
  logic             vld_q, last_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sad_q <= '0; idx_q <= '0; vld_q <= 1'b0; last_q <= 1'b0;
    end else begin
      vld_q  <= cand_valid;
      last_q <= cand_valid & cand_last;
      if (cand_valid) begin
        sad_q <= sad_c;
        idx_q <= cand_idx;
      end
    end

  // Stage 2: running minimum
  logic [SAD_W-1:0] min_q;
  logic [IDX_W-1:0] min_idx_q;
  logic             done_q, take;

  assign take = vld_q & ~start & ~ge_sad(sad_q, min_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      min_q <= '1; min_idx_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= vld_q & last_q & ~start;
      if (start) begin
        min_q     <= '1;
        min_idx_q <= '0;
      end else if (take) begin
        min_q     <= sad_q;
        min_idx_q <= idx_q;
      end
    end

  assign done     = done_q;
  assign best_sad = min_q;
  assign best_idx = min_idx_q;

  p_sad_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (32'(sad_q) <= SAD_MAX));

  p_start_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (best_sad == '1 && best_idx == '0));

  p_min_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (best_sad <= $past(best_sad)));

  p_tie_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && vld_q && sad_q >= best_sad) |=> $stable(best_idx));

  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && last_q && !start) |=> done);

  p_done_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(vld_q && last_q));

endmodule

// File: tb/sad_min_search_tb.sv
module sad_min_search_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic clk = 0, rst_n = 0;
  logic ref_load = 0, start = 0, cand_valid = 0, cand_last = 0;
  logic [NP*8-1:0] ref_pix = '0, cand_pix = '0;
  logic [7:0] cand_idx = '0;
  logic done;
  logic [11:0] best_sad;
  logic [7:0] best_idx;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  sad_min_search u_dut (
    .clk(clk), .rst_n(rst_n), .ref_load(ref_load), .ref_pix(ref_pix),
    .start(start), .cand_valid(cand_valid), .cand_last(cand_last),
    .cand_pix(cand_pix), .cand_idx(cand_idx),
    .done(done), .best_sad(best_sad), .best_idx(best_idx));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int  m_ref [NP];
  int  m_best = 4095, m_idx = 0;
  bit  m_done = 0;
  bit  p_v = 0, p_last = 0;
  int  p_sad = 0, p_idx = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_best = 4095; m_idx = 0; m_done = 0; p_v = 0; p_last = 0;
      foreach (m_ref[k]) m_ref[k] = 0;
    end else begin
      m_done = p_v && p_last && !start;
      if (start) begin
        m_best = 4095; m_idx = 0;
      end else if (p_v && p_sad < m_best) begin
        m_best = p_sad; m_idx = p_idx;
      end
      p_v = cand_valid;
      p_last = cand_valid && cand_last;
      if (cand_valid) begin
        int s;
        s = 0;
        for (int k = 0; k < NP; k++) begin
          int d;
          d = int'(cand_pix[k*8 +: 8]) - m_ref[k];
          s += (d < 0) ? -d : d;
        end
        p_sad = s;
        p_idx = int'(cand_idx);
      end
      if (ref_load) for (int k = 0; k < NP; k++) m_ref[k] = int'(ref_pix[k*8 +: 8]);
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R8 model done", int'(done), int'(m_done));
    chk("R6 model best_sad", int'(best_sad), m_best);
    chk("R6 model best_idx", int'(best_idx), m_idx);
  end

  function automatic logic [NP*8-1:0] fill(input int v);
    logic [NP*8-1:0] r;
    for (int k = 0; k < NP; k++) r[k*8 +: 8] = 8'(v);
    return r;
  endfunction

  task automatic load_ref(input logic [NP*8-1:0] p);
    @(negedge clk); ref_pix = p; ref_load = 1;
    @(negedge clk); ref_load = 0;
  endtask

  task automatic go();
    @(negedge clk); start = 1; cand_valid = 0;
    @(negedge clk); start = 0;
  endtask

  task automatic put(input logic [NP*8-1:0] p, input int idx, input bit last);
    @(negedge clk); cand_pix = p; cand_idx = 8'(idx); cand_last = last; cand_valid = 1;
  endtask

  // after last candidate was put: expects done in cycle c+2 with given result
  task automatic finish_check(input string tag, input int exp_sad, input int exp_idx);
    @(negedge clk); cand_valid = 0; cand_last = 0;
    chk({tag, " R8 done not early"}, int'(done), 0);
    @(negedge clk);
    chk({tag, " R8 done at c+2"}, int'(done), 1);
    chk({tag, " sad"}, int'(best_sad), exp_sad);
    chk({tag, " idx"}, int'(best_idx), exp_idx);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, int'(done), 0);
  endtask

  initial begin
    logic [NP*8-1:0] ramp, one_hot;
    for (int k = 0; k < NP; k++) ramp[k*8 +: 8] = 8'(100 + k);
    one_hot = '0; one_hot[15*8 +: 8] = 8'd200;

    repeat (2) @(negedge clk);
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset best_sad", int'(best_sad), 4095);
    chk("R9 reset best_idx", int'(best_idx), 0);
    @(negedge clk); rst_n = 1;

    // R6: running minimum over three candidates
    load_ref(fill(100));
    go();
    put(fill(90), 5, 0);
    put(fill(110), 6, 0);
    put(ramp, 7, 1);
    finish_check("R6 min of three", 120, 7);

    // R2 and R7: symmetric difference, tie keeps earlier index
    go();
    put(fill(110), 3, 0);
    put(fill(90), 4, 1);
    finish_check("R2 R7 tie keeps earlier", 160, 3);

    // R3: extreme SAD
    load_ref(fill(0));
    go();
    put(fill(255), 9, 1);
    finish_check("R3 max sad 4080", 4080, 9);

    // R1: pixel position pairing
    load_ref(one_hot);
    go();
    put(fill(0), 11, 0);
    put(one_hot, 12, 0);
    put(fill(200), 13, 1);
    finish_check("R1 position pairing", 0, 12);

    // R4: candidate in flight discarded by start
    load_ref(fill(50));
    go();
    put(fill(50), 1, 0);
    @(negedge clk); cand_valid = 0; start = 1;
    @(negedge clk); start = 0;
    chk("R4 start clears sad", int'(best_sad), 4095);
    chk("R4 start clears idx", int'(best_idx), 0);
    @(negedge clk);
    chk("R4 in-flight dropped", int'(best_sad), 4095);

    // R5: invalid cycles ignored
    put(fill(60), 2, 0);
    @(negedge clk); cand_valid = 0; cand_pix = fill(50); cand_idx = 8'd3; cand_last = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 invalid ignored no done", int'(done), 0);
    put(fill(40), 4, 1);
    finish_check("R5 invalid ignored", 160, 2);

    // R5: back-to-back candidates with no gaps
    go();
    for (int i = 0; i < 8; i++) put(fill(50 + 8 - i), 20 + i, i == 7);
    finish_check("R5 back-to-back", 16, 27);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule